// File: doc/BRIEF.md
# Trigger-Indexed Hit Buffer

This block keeps detector hits in a memory addressed directly by their coordinates, not in arrival order. A 4-bit pixel row picks one of 16 banks, an 8-bit time stamp picks one of 256 word-lines in that bank, and a 5-bit pixel column picks one of 32 cells on the word-line. Each cell holds a hit flag and a 3-bit pulse height. One time-stamp tick stands for 100 ns, so the memory spans about 25.6 µs of history before it wraps. The running time stamp `ts_now` drives the wrap: when it moves onto a word-line, that word-line is wiped in every bank.

A level-1 trigger names a target time stamp. To absorb trigger jitter, the block scans three word-lines: target−1, target and target+1, taken modulo 256. It emits one record for every set cell over a valid/ready handshake and then pulses a done flag. Triggers wait in a 4-entry queue while a scan is running. If the queue is full, the trigger is dropped and a one-cycle drop pulse is raised.

The readout controller is a four-state machine. IDLE waits for a queued trigger. On IDLE→LOAD it pops the trigger and starts at window slot 0, bank 0. LOAD copies the addressed bank word into a shadow register, then goes to EMIT. EMIT presents the lowest set column of the shadow and clears that bit when the record is accepted. When the shadow is empty, EMIT→LOAD moves to the next bank, or to the next slot after bank 15. EMIT→DONE happens after bank 15 of slot 2. DONE pulses the done output and returns to IDLE.

Top module: `trig_hit_buffer`

## Requirements
- R1: After reset, `out_valid`, `out_done` and `trig_drop` are low and every hit flag is clear, so a trigger yields no records.
- R2: A hit written with row r, column c, time stamp t and pulse height p is reported as `out_bank`=r, `out_col`=c, `out_ts`=t, `out_ph`=p.
- R3: A trigger at time stamp T reports only hits whose time stamp is T−1, T or T+1. Records come in this order: window slot (T−1 first), then ascending bank, then ascending column.
- R4: The window arithmetic wraps modulo 256, so T=0 covers word-lines 255, 0 and 1.
- R5: When `ts_now` changes to value V, word-line V is cleared in all banks. A hit written to word-line V in that same cycle is kept.
- R6: Writing an already set cell again keeps one record for it, carrying the newest pulse height.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and the record fields stay unchanged.
- R8: `out_done` pulses for exactly one cycle after the last record of a window. It also pulses when the window holds no hits.
- R9: Up to 4 triggers wait in a queue during a scan, and they are served in arrival order.
- R10: A trigger that arrives when the queue is full and nothing is popped is dropped. `trig_drop` pulses high for one cycle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_now | input | 8 | Running time stamp; a change clears the word-line it now names |
| hit_valid | input | 1 | Write strobe for one hit |
| hit_row | input | 4 | Pixel row (bank select) |
| hit_col | input | 5 | Pixel column (cell select) |
| hit_ts | input | 8 | Hit time stamp (word-line select) |
| hit_ph | input | 3 | Pulse height |
| trig_valid | input | 1 | Trigger strobe |
| trig_ts | input | 8 | Trigger target time stamp |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer accepts record |
| out_bank | output | 4 | Record bank (pixel row) |
| out_col | output | 5 | Record column |
| out_ts | output | 8 | Record time stamp |
| out_ph | output | 3 | Record pulse height |
| out_done | output | 1 | One-cycle end-of-window pulse |
| trig_drop | output | 1 | One-cycle pulse for a dropped trigger |

## Verification
The hardest case to reach is an overflowing trigger queue, because the queue only fills while a scan is running. The stimulus gets there by sending six triggers on consecutive cycles at an empty window. Even an empty window takes close to a hundred cycles to scan, so five triggers are held and the sixth is dropped. A second hard case is a clear that lands in the same cycle as a write to the same word-line. The bench moves `ts_now` onto a word-line with a stale hit while writing a fresh hit there, then checks that only the fresh one comes back.

// File: rtl/thb_pkg.sv
package thb_pkg;
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_LOAD = 2'd1,
        RD_EMIT = 2'd2,
        RD_DONE = 2'd3
    } rd_state_e;
endpackage

// File: rtl/thb_hit_store.sv
module thb_hit_store #(
    parameter int BANK_W = 4,
    parameter int TS_W   = 8,
    parameter int COL_W  = 5,
    parameter int PH_W   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [TS_W-1:0]           ts_now,
    input  logic                      wr_en,
    input  logic [BANK_W-1:0]         wr_bank,
    input  logic [COL_W-1:0]          wr_col,
    input  logic [TS_W-1:0]           wr_ts,
    input  logic [PH_W-1:0]           wr_ph,
    input  logic [BANK_W-1:0]         rd_bank,
    input  logic [TS_W-1:0]           rd_row,
    output logic [(1<<COL_W)-1:0]     rd_hits,
    output logic [(1<<COL_W)*PH_W-1:0] rd_ph
);
    localparam int BANKS = 1 << BANK_W;
    localparam int ROWS  = 1 << TS_W;
    localparam int COLS  = 1 << COL_W;

    logic [COLS-1:0]      hit_q [BANKS][ROWS];
    logic [COLS*PH_W-1:0] ph_q  [BANKS][ROWS];
    logic [TS_W-1:0]      ts_prev;
    logic                 clr_en;

    assign clr_en = (ts_now != ts_prev);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts_prev <= '0;
            for (int b = 0; b < BANKS; b++) begin
                for (int r = 0; r < ROWS; r++) begin
                    hit_q[b][r] <= '0;
                end
            end
        end else begin
            ts_prev <= ts_now;
            if (clr_en) begin
                for (int b = 0; b < BANKS; b++) begin
                    hit_q[b][ts_now] <= '0;
                end
            end
            if (wr_en) begin
                hit_q[wr_bank][wr_ts][wr_col] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            ph_q[wr_bank][wr_ts][wr_col*PH_W +: PH_W] <= wr_ph;
        end
    end

    assign rd_hits = hit_q[rd_bank][rd_row];
    assign rd_ph   = ph_q[rd_bank][rd_row];

    // R5
    clear_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(wr_en && wr_ts == ts_now)) |=> (hit_q[0][$past(ts_now)] == '0));
endmodule

// File: rtl/thb_trig_queue.sv
module thb_trig_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         drop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             full, accept, take;

    assign full   = (cnt == CNT_W'(DEPTH));
    assign empty  = (cnt == '0);
    assign take   = pop && !empty;
    assign accept = push && (!full || take);
    assign dout   = slots[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            drop   <= 1'b0;
        end else begin
            drop <= push && !accept;
            if (accept) wr_ptr <= bump(wr_ptr);
            if (take)   rd_ptr <= bump(rd_ptr);
            cnt <= cnt + CNT_W'(accept) - CNT_W'(take);
        end
    end

    always_ff @(posedge clk) begin
        if (accept) slots[wr_ptr] <= din;
    end

    // R9
    qcount_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));
    // R10
    drop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> drop);
endmodule

// File: rtl/thb_readout.sv
module thb_readout
    import thb_pkg::*;
#(
    parameter int BANK_W = 4,
    parameter int TS_W   = 8,
    parameter int COL_W  = 5,
    parameter int PH_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       q_empty,
    input  logic [TS_W-1:0]            q_dout,
    output logic                       q_pop,
    output logic [BANK_W-1:0]          rd_bank,
    output logic [TS_W-1:0]            rd_row,
    input  logic [(1<<COL_W)-1:0]      rd_hits,
    input  logic [(1<<COL_W)*PH_W-1:0] rd_ph,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [BANK_W-1:0]          out_bank,
    output logic [COL_W-1:0]           out_col,
    output logic [TS_W-1:0]            out_ts,
    output logic [PH_W-1:0]            out_ph,
    output logic                       out_done
);
    localparam int COLS = 1 << COL_W;
    localparam logic [BANK_W-1:0] LAST_BANK = '1;
    localparam logic [1:0]        LAST_SLOT = 2'd2;

    rd_state_e            state, nxt;
    logic [TS_W-1:0]      tgt;
    logic [1:0]           slot;
    logic [BANK_W-1:0]    bank;
    logic [COLS-1:0]      sh_hits;
    logic [COLS*PH_W-1:0] sh_ph;
    logic [COL_W-1:0]     lo;
    logic                 sh_any;

    function automatic logic [COL_W-1:0] lowest(input logic [COLS-1:0] v);
        logic [COL_W-1:0] idx;
        idx = '0;
        for (int i = COLS - 1; i >= 0; i--) begin
            if (v[i]) idx = COL_W'(i);
        end
        return idx;
    endfunction

    assign lo     = lowest(sh_hits);
    assign sh_any = |sh_hits;
    assign rd_row = tgt + TS_W'(slot) - TS_W'(1);

    always_comb begin
        nxt = state;
        unique case (state)
            RD_IDLE: if (!q_empty) nxt = RD_LOAD;
            RD_LOAD: nxt = RD_EMIT;
            RD_EMIT: begin
                if (!sh_any) begin
                    nxt = (bank == LAST_BANK && slot == LAST_SLOT) ? RD_DONE : RD_LOAD;
                end
            end
            RD_DONE: nxt = RD_IDLE;
            default: nxt = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= RD_IDLE;
            tgt     <= '0;
            slot    <= '0;
            bank    <= '0;
            sh_hits <= '0;
            sh_ph   <= '0;
        end else begin
            state <= nxt;
            unique case (state)
                RD_IDLE: begin
                    if (!q_empty) begin
                        tgt  <= q_dout;
                        slot <= '0;
                        bank <= '0;
                    end
                end
                RD_LOAD: begin
                    sh_hits <= rd_hits;
                    sh_ph   <= rd_ph;
                end
                RD_EMIT: begin
                    if (sh_any) begin
                        if (out_ready) sh_hits[lo] <= 1'b0;
                    end else if (bank == LAST_BANK) begin
                        bank <= '0;
                        slot <= slot + 2'd1;
                    end else begin
                        bank <= bank + BANK_W'(1);
                    end
                end
                RD_DONE: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        q_pop     = (state == RD_IDLE) && !q_empty;
        rd_bank   = bank;
        out_valid = (state == RD_EMIT) && sh_any;
        out_bank  = bank;
        out_col   = lo;
        out_ts    = rd_row;
        out_ph    = sh_ph[lo*PH_W +: PH_W];
        out_done  = (state == RD_DONE);
    end

    // R7
    hold_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable({out_bank, out_col, out_ts, out_ph})));
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_done);
endmodule

// File: rtl/trig_hit_buffer.sv
module trig_hit_buffer #(
    parameter int BANK_W   = 4,
    parameter int TS_W     = 8,
    parameter int COL_W    = 5,
    parameter int PH_W     = 3,
    parameter int TQ_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   ts_now,
    input  logic              hit_valid,
    input  logic [BANK_W-1:0] hit_row,
    input  logic [COL_W-1:0]  hit_col,
    input  logic [TS_W-1:0]   hit_ts,
    input  logic [PH_W-1:0]   hit_ph,
    input  logic              trig_valid,
    input  logic [TS_W-1:0]   trig_ts,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BANK_W-1:0] out_bank,
    output logic [COL_W-1:0]  out_col,
    output logic [TS_W-1:0]   out_ts,
    output logic [PH_W-1:0]   out_ph,
    output logic              out_done,
    output logic              trig_drop
);
    localparam int COLS = 1 << COL_W;

    logic [BANK_W-1:0]    rd_bank;
    logic [TS_W-1:0]      rd_row;
    logic [COLS-1:0]      rd_hits;
    logic [COLS*PH_W-1:0] rd_ph;
    logic [TS_W-1:0]      q_dout;
    logic                 q_empty, q_pop;

    thb_hit_store #(.BANK_W(BANK_W), .TS_W(TS_W), .COL_W(COL_W), .PH_W(PH_W)) u_store (
        .clk(clk), .rst_n(rst_n), .ts_now(ts_now),
        .wr_en(hit_valid), .wr_bank(hit_row), .wr_col(hit_col), .wr_ts(hit_ts), .wr_ph(hit_ph),
        .rd_bank(rd_bank), .rd_row(rd_row), .rd_hits(rd_hits), .rd_ph(rd_ph)
    );

    thb_trig_queue #(.DEPTH(TQ_DEPTH), .W(TS_W)) u_tq (
        .clk(clk), .rst_n(rst_n), .push(trig_valid), .din(trig_ts),
        .pop(q_pop), .dout(q_dout), .empty(q_empty), .drop(trig_drop)
    );

    thb_readout #(.BANK_W(BANK_W), .TS_W(TS_W), .COL_W(COL_W), .PH_W(PH_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_dout(q_dout), .q_pop(q_pop),
        .rd_bank(rd_bank), .rd_row(rd_row), .rd_hits(rd_hits), .rd_ph(rd_ph),
        .out_valid(out_valid), .out_ready(out_ready), .out_bank(out_bank),
        .out_col(out_col), .out_ts(out_ts), .out_ph(out_ph), .out_done(out_done)
    );
endmodule

// File: tb/trig_hit_buffer_tb.sv
module trig_hit_buffer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ts_now = '0;
    logic       hit_valid = 1'b0;
    logic [3:0] hit_row = '0;
    logic [4:0] hit_col = '0;
    logic [7:0] hit_ts = '0;
    logic [2:0] hit_ph = '0;
    logic       trig_valid = 1'b0;
    logic [7:0] trig_ts = '0;
    logic       out_ready = 1'b1;
    logic       out_valid, out_done, trig_drop;
    logic [3:0] out_bank;
    logic [4:0] out_col;
    logic [7:0] out_ts;
    logic [2:0] out_ph;

    trig_hit_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .ts_now(ts_now), .hit_valid(hit_valid),
        .hit_row(hit_row), .hit_col(hit_col), .hit_ts(hit_ts), .hit_ph(hit_ph),
        .trig_valid(trig_valid), .trig_ts(trig_ts), .out_valid(out_valid),
        .out_ready(out_ready), .out_bank(out_bank), .out_col(out_col),
        .out_ts(out_ts), .out_ph(out_ph), .out_done(out_done), .trig_drop(trig_drop)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // hit table: {row[3:0], col[4:0], ts[7:0], ph[2:0]}
    localparam int NHIT = 12;
    localparam logic [19:0] HIT_TBL [NHIT] = '{
        {4'd3,  5'd7,  8'd10,  3'd5},
        {4'd3,  5'd2,  8'd10,  3'd1},
        {4'd0,  5'd31, 8'd9,   3'd7},
        {4'd15, 5'd0,  8'd11,  3'd2},
        {4'd7,  5'd16, 8'd8,   3'd3},
        {4'd2,  5'd4,  8'd12,  3'd6},
        {4'd9,  5'd9,  8'd11,  3'd0},
        {4'd5,  5'd5,  8'd255, 3'd4},
        {4'd6,  5'd6,  8'd0,   3'd1},
        {4'd1,  5'd1,  8'd1,   3'd2},
        {4'd4,  5'd4,  8'd2,   3'd3},
        {4'd3,  5'd7,  8'd10,  3'd6}
    };

    bit       mhit [16][256][32];
    bit [2:0] mph  [16][256][32];

    logic [3:0] eb [64];
    logic [4:0] ec [64];
    logic [7:0] et [64];
    logic [2:0] ep [64];
    int         en;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R8: run hung, actual cycles %0d expected < 150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic mclear(input int r);
        for (int b = 0; b < 16; b++)
            for (int c = 0; c < 32; c++) mhit[b][r][c] = 1'b0;
    endtask

    task automatic put_hit(input logic [3:0] b, input logic [4:0] c,
                           input logic [7:0] t, input logic [2:0] p);
        @(negedge clk);
        hit_valid = 1'b1; hit_row = b; hit_col = c; hit_ts = t; hit_ph = p;
        mhit[b][t][c] = 1'b1;
        mph[b][t][c]  = p;
        @(negedge clk);
        hit_valid = 1'b0;
    endtask

    task automatic fire(input logic [7:0] t);
        @(negedge clk);
        trig_valid = 1'b1; trig_ts = t;
        @(negedge clk);
        trig_valid = 1'b0;
    endtask

    task automatic build_exp(input logic [7:0] t);
        en = 0;
        for (int w = 0; w < 3; w++) begin
            logic [7:0] r;
            r = t + 8'(w) - 8'd1;
            for (int b = 0; b < 16; b++)
                for (int c = 0; c < 32; c++)
                    if (mhit[b][r][c]) begin
                        eb[en] = 4'(b); ec[en] = 5'(c); et[en] = r; ep[en] = mph[b][r][c];
                        en++;
                    end
        end
    endtask

    // collect one window with a stalling ready pattern and compare records
    task automatic collect(input logic [7:0] t, input string req);
        int n = 0, guard = 0;
        bit done_seen = 0, stalled = 0;
        logic [19:0] held;
        build_exp(t);
        while (!done_seen && guard < 3000) begin
            @(negedge clk);
            guard++;
            if (stalled) begin
                check(out_valid && {out_bank, out_col, out_ts, out_ph} == held,
                      "R7", "record held during stall", int'({out_bank, out_col, out_ts, out_ph}), int'(held));
                stalled = 0;
            end
            if (out_done) begin
                done_seen = 1;
                out_ready = 1'b1;
            end else if (out_valid) begin
                out_ready = (guard % 3 != 1);
                if (out_ready) begin
                    if (n < en)
                        check({out_bank, out_col, out_ts, out_ph} == {eb[n], ec[n], et[n], ep[n]},
                              req, "record (bank,col,ts,ph packed)",
                              int'({out_bank, out_col, out_ts, out_ph}), int'({eb[n], ec[n], et[n], ep[n]}));
                    n++;
                end else begin
                    stalled = 1;
                    held = {out_bank, out_col, out_ts, out_ph};
                end
            end
        end
        out_ready = 1'b1;
        check(done_seen, "R8", "done pulse seen", int'(done_seen), 1);
        check(n == en, req, "record count", n, en);
        @(negedge clk);
        check(!out_done, "R8", "done is one cycle wide", int'(out_done), 0);
    endtask

    initial begin
        int drops, dones;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!out_valid && !out_done && !trig_drop, "R1", "outputs low in reset",
              int'({out_valid, out_done, trig_drop}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !out_done && !trig_drop, "R1", "outputs low after reset",
              int'({out_valid, out_done, trig_drop}), 0);

        // table walk: write hits (R2, R6 via last entry rewriting a cell)
        for (int i = 0; i < NHIT; i++) begin
            put_hit(HIT_TBL[i][19:16], HIT_TBL[i][15:11], HIT_TBL[i][10:3], HIT_TBL[i][2:0]);
        end
        // R3 window and order, R2 fields, R6 newest pulse height on rewritten cell
        fire(8'd10);
        collect(8'd10, "R3");
        // R4 wrap at zero
        fire(8'd0);
        collect(8'd0, "R4");
        // R9: two queued triggers served in order
        fire(8'd11);
        fire(8'd1);
        collect(8'd11, "R9");
        collect(8'd1, "R9");

        // R5: clear on time-stamp change, same-cycle write survives
        put_hit(4'd2, 5'd3, 8'd20, 3'd1);
        put_hit(4'd2, 5'd3, 8'd21, 3'd4);
        @(negedge clk);
        ts_now = 8'd20;
        mclear(20);
        @(negedge clk);
        ts_now = 8'd21;
        mclear(21);
        hit_valid = 1'b1; hit_row = 4'd4; hit_col = 5'd8; hit_ts = 8'd21; hit_ph = 3'd5;
        mhit[4][21][8] = 1'b1; mph[4][21][8] = 3'd5;
        @(negedge clk);
        hit_valid = 1'b0;
        fire(8'd21);
        collect(8'd21, "R5");

        // R8: empty window still gives done
        fire(8'd100);
        collect(8'd100, "R8");

        // R10: six back-to-back triggers during a scan
        drops = 0; dones = 0;
        @(negedge clk);
        trig_valid = 1'b1; trig_ts = 8'd100;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (trig_drop) drops++;
            if (out_done) dones++;
        end
        trig_valid = 1'b0;
        for (int k = 0; k < 1200; k++) begin
            @(negedge clk);
            if (trig_drop) drops++;
            if (out_done) dones++;
        end
        check(drops == 1, "R10", "dropped triggers", drops, 1);
        check(dones == 5, "R9", "windows served from full queue", dones, 5);

        // R1: reset clears memory
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!out_valid && !out_done && !trig_drop, "R1", "outputs low in second reset",
              int'({out_valid, out_done, trig_drop}), 0);
        rst_n = 1'b1;
        ts_now = 8'd0;
        for (int b = 0; b < 16; b++)
            for (int r = 0; r < 256; r++)
                for (int c = 0; c < 32; c++) mhit[b][r][c] = 1'b0;
        fire(8'd10);
        collect(8'd10, "R1");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule